// File: doc/BRIEF.md
# MFM Sector Read Deserializer

This block turns a raw MFM read-pulse stream from a disk drive into framed bytes. It runs on a clock at a fixed multiple of the bit rate (16x by default). A phase counter with a small correction loop splits each bit cell into a clock half and a data half. A transition that falls in the data half decodes as a one. A transition in the clock half, or no transition at all, decodes as a zero.

A read is armed by the falling edge of the sector pulse, and only while the start-read enable is high. The phase counter restarts on that edge. The block then counts the preamble zeros until it sees a single marker one. If the preamble is long enough, it raises a sync-found flag and delivers every following group of eight cells as a byte with a one-cycle strobe. If the marker comes after too few zeros, or does not arrive within a fixed number of cells, a sync-error flag is raised instead. Any later falling sector edge abandons the read in progress.

Top module: `mfm_sector_reader`

## Requirements
- R1: After reset, byte_out is 0 and byte_vld, sync_found and sync_err are all low.
- R2: A falling edge of sector_pulse while rd_en is high arms a preamble search. A falling edge while rd_en is low leaves the block idle: no flag is set and no byte is delivered, even when a full preamble, marker and data follow.
- R3: Bit cells are counted from the falling sector edge, each OVS ticks long. A transition in the second half of a cell (ticks OVS/2 to OVS-1) decodes as a one. A transition in the first half, or no transition, decodes as a zero.
- R4: A one that follows at least MIN_ZEROS (16) zero cells sets sync_found, which stays high until the next falling sector edge. This holds for exactly 16 zeros.
- R5: A one that follows fewer than MIN_ZEROS zero cells (for example 15) sets sync_err, and no byte follows. sync_found and sync_err are never high together.
- R6: If cell SYNC_WINDOW (64) after the sector edge is still a zero, sync_err is set. A marker in cell 64, after 63 zeros, still succeeds.
- R7: After the marker, every eight cells form one byte. The first cell after the marker is bit 7, so bytes are shifted in most significant bit first. Each byte is shown on byte_out with byte_vld high for exactly one cycle, and byte_out changes only at that strobe.
- R8: A falling sector edge during a read aborts it and clears both flags. A partly collected byte is dropped, and the new read starts a fresh search.
- R9: Decoding stays correct under two conditions. The first is timing jitter of one tick on every transition. The second is a bit rate about 1.5% slower than nominal, with one cell in four lasting 17 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, OVS times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_pulse | input | 1 | Raw read pulse from the drive; each rising edge is one flux transition |
| sector_pulse | input | 1 | Sector pulse; its falling edge marks the start of the first bit cell |
| rd_en | input | 1 | Start-read enable, sampled at the falling sector edge |
| byte_out | output | BYTE_W | Last assembled byte, most significant bit received first |
| byte_vld | output | 1 | One-cycle strobe marking a new byte on byte_out |
| sync_found | output | 1 | The preamble and marker were accepted for this sector |
| sync_err | output | 1 | The preamble was too short, or no marker came within the window |

## Verification
A phase counter that slips shows up quickly. Once the cell boundary drifts by more than a quarter cell, a clock-half transition is read as a one, and the next byte or flag is wrong within one or two cells. A wrong preamble zero count shows up at the marker cell: sync_found and sync_err swap. A bit counter that is off by one produces bytes that are rotated, or a strobe one cell early or late, on the very first byte after the marker. The bench keeps a queue of the expected bytes and compares it with every strobe as it happens. It also checks the flags at the end of each sector, and covers the boundary preamble lengths 15, 16 and 63, as well as the no-marker case.

// File: rtl/mfm_rd_pkg.sv
package mfm_rd_pkg;
   typedef enum logic [1:0] {
      FR_IDLE = 2'd0,
      FR_HUNT = 2'd1,
      FR_DATA = 2'd2
   } fr_state_t;
endpackage

// File: rtl/mfm_edge_sync.sv
module mfm_edge_sync #(
   parameter int STAGES  = 2,
   parameter bit IDLE    = 1'b0,
   parameter bit FALLING = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic edge_o
);
   typedef logic [STAGES-1:0] pipe_t;

   pipe_t pipe;
   logic  prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= {STAGES{IDLE}};
         prev <= IDLE;
      end else begin
         pipe <= pipe_t'({pipe, din});
         prev <= pipe[STAGES-1];
      end
   end

   if (FALLING) begin : g_fall
      assign edge_o = prev & ~pipe[STAGES-1];
   end else begin : g_rise
      assign edge_o = ~prev & pipe[STAGES-1];
   end
endmodule

// File: rtl/mfm_phase_track.sv
module mfm_phase_track #(
   parameter int OVS   = 16,
   parameter bit TRACK = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic rise,
   output logic cell_stb,
   output logic cell_bit
);
   localparam int PW    = $clog2(OVS);
   localparam int HALF  = OVS / 2;
   localparam int CLK_C = OVS / 4;
   localparam int DAT_C = (3 * OVS) / 4;

   logic [PW-1:0] ph;
   logic [PW:0]   ph_sum;
   logic [1:0]    step;
   logic          data_seen;
   logic          in_data;
   logic [PW-1:0] centre;

   assign in_data = (ph >= PW'(HALF));
   assign centre  = in_data ? PW'(DAT_C) : PW'(CLK_C);

   if (TRACK) begin : g_track
      // nudge the boundary one tick toward the observed transition
      always_comb begin
         step = 2'd1;
         if (rise) begin
            if (ph > centre)      step = 2'd0;
            else if (ph < centre) step = 2'd2;
         end
      end
   end else begin : g_free
      logic unused_centre;
      assign unused_centre = ^centre;
      assign step = 2'd1;
   end

   assign ph_sum   = {1'b0, ph} + (PW+1)'(step);
   assign cell_stb = ph_sum[PW];
   assign cell_bit = data_seen | (rise & in_data);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= '0;
         data_seen <= 1'b0;
      end else if (restart) begin
         ph        <= PW'(1);
         data_seen <= 1'b0;
      end else begin
         ph <= ph_sum[PW-1:0];
         if (cell_stb)
            data_seen <= 1'b0;
         else if (rise && in_data)
            data_seen <= 1'b1;
      end
   end
endmodule

// File: rtl/mfm_framer.sv
module mfm_framer
   import mfm_rd_pkg::*;
#(
   parameter int MIN_ZEROS   = 16,
   parameter int SYNC_WINDOW = 64,
   parameter int BYTE_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              disarm,
   input  logic              cell_stb,
   input  logic              cell_bit,
   output logic [BYTE_W-1:0] byte_out,
   output logic              byte_vld,
   output logic              sync_found,
   output logic              sync_err
);
   localparam int CW = $clog2(SYNC_WINDOW + 1);
   localparam int NW = $clog2(BYTE_W);

   fr_state_t         st;
   logic [CW-1:0]     cells;
   logic [CW-1:0]     cells_p1;
   logic [CW-1:0]     zeros;
   logic [NW-1:0]     nbits;
   logic [BYTE_W-2:0] shreg;
   logic [BYTE_W-1:0] nxt;

   assign cells_p1 = cells + CW'(1);
   assign nxt      = {shreg, cell_bit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= FR_IDLE;
         cells      <= '0;
         zeros      <= '0;
         nbits      <= '0;
         shreg      <= '0;
         byte_out   <= '0;
         byte_vld   <= 1'b0;
         sync_found <= 1'b0;
         sync_err   <= 1'b0;
      end else begin
         byte_vld <= 1'b0;
         if (arm || disarm) begin
            st         <= arm ? FR_HUNT : FR_IDLE;
            cells      <= '0;
            zeros      <= '0;
            nbits      <= '0;
            sync_found <= 1'b0;
            sync_err   <= 1'b0;
         end else if (cell_stb) begin
            case (st)
               FR_HUNT: begin
                  cells <= cells_p1;
                  if (cell_bit) begin
                     if (zeros >= CW'(MIN_ZEROS)) begin
                        sync_found <= 1'b1;
                        st         <= FR_DATA;
                        nbits      <= '0;
                     end else begin
                        sync_err <= 1'b1;
                        st       <= FR_IDLE;
                     end
                  end else if (cells_p1 >= CW'(SYNC_WINDOW)) begin
                     sync_err <= 1'b1;
                     st       <= FR_IDLE;
                  end else begin
                     zeros <= zeros + CW'(1);
                  end
               end
               FR_DATA: begin
                  shreg <= nxt[BYTE_W-2:0];
                  if (nbits == NW'(BYTE_W - 1)) begin
                     byte_out <= nxt;
                     byte_vld <= 1'b1;
                     nbits    <= '0;
                  end else begin
                     nbits <= nbits + NW'(1);
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/mfm_sector_reader.sv
module mfm_sector_reader #(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2,
   parameter int MIN_ZEROS   = 16,
   parameter int SYNC_WINDOW = 64,
   parameter int BYTE_W      = 8,
   parameter bit TRACK_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_pulse,
   input  logic              sector_pulse,
   input  logic              rd_en,
   output logic [BYTE_W-1:0] byte_out,
   output logic              byte_vld,
   output logic              sync_found,
   output logic              sync_err
);
   if (OVS < 8 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
      $error("OVS must be a power of two and at least 8");
   end
   if (MIN_ZEROS < 1 || MIN_ZEROS >= SYNC_WINDOW) begin : g_bad_win
      $error("MIN_ZEROS must lie between 1 and SYNC_WINDOW-1");
   end
   if (BYTE_W < 2) begin : g_bad_byte
      $error("BYTE_W must be at least 2");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   logic rd_rise;
   logic sec_fall;
   logic cell_stb;
   logic cell_bit;

   mfm_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b0), .FALLING(1'b0)) u_rd_sync (
      .clk(clk), .rst_n(rst_n), .din(rd_pulse), .edge_o(rd_rise));

   mfm_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1), .FALLING(1'b1)) u_sec_sync (
      .clk(clk), .rst_n(rst_n), .din(sector_pulse), .edge_o(sec_fall));

   mfm_phase_track #(.OVS(OVS), .TRACK(TRACK_EN)) u_track (
      .clk(clk), .rst_n(rst_n), .restart(sec_fall), .rise(rd_rise),
      .cell_stb(cell_stb), .cell_bit(cell_bit));

   mfm_framer #(.MIN_ZEROS(MIN_ZEROS), .SYNC_WINDOW(SYNC_WINDOW), .BYTE_W(BYTE_W)) u_framer (
      .clk(clk), .rst_n(rst_n),
      .arm(sec_fall & rd_en), .disarm(sec_fall & ~rd_en),
      .cell_stb(cell_stb), .cell_bit(cell_bit),
      .byte_out(byte_out), .byte_vld(byte_vld),
      .sync_found(sync_found), .sync_err(sync_err));
endmodule

// File: rtl/mfm_sector_reader_chk.sv
module mfm_sector_reader_chk #(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sec_fall,
   input logic              rd_en,
   input logic [BYTE_W-1:0] byte_out,
   input logic              byte_vld,
   input logic              sync_found,
   input logic              sync_err
);
   assert_vld_after_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |-> sync_found);

   assert_flags_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(sync_found && sync_err));

   assert_vld_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |=> !byte_vld);

   assert_byte_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_vld |-> $stable(byte_out));

   assert_rearm_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sec_fall |=> (!sync_found && !sync_err));

   assert_disarm_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_fall && !rd_en) |=> !byte_vld);
endmodule

bind mfm_sector_reader mfm_sector_reader_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sec_fall(sec_fall), .rd_en(rd_en),
   .byte_out(byte_out), .byte_vld(byte_vld),
   .sync_found(sync_found), .sync_err(sync_err));

// File: tb/tb_mfm_sector_reader.sv
module tb_mfm_sector_reader;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rd_pulse = 1'b0;
   logic       sector_pulse = 1'b1;
   logic       rd_en = 1'b0;
   logic [7:0] byte_out;
   logic       byte_vld;
   logic       sync_found;
   logic       sync_err;

   int          n_chk = 0;
   int          n_fail = 0;
   int          cyc = 0;
   int unsigned lcg = 32'h1234_5678;
   logic [7:0]  exp_q[$];
   bit          bits_q[$];

   mfm_sector_reader dut (
      .clk(clk), .rst_n(rst_n), .rd_pulse(rd_pulse), .sector_pulse(sector_pulse),
      .rd_en(rd_en), .byte_out(byte_out), .byte_vld(byte_vld),
      .sync_found(sync_found), .sync_err(sync_err));

   always #10 clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // every-clock comparison against the expected byte queue
   always @(negedge clk) begin
      if (rst_n) begin
         if (sync_found && sync_err)
            check(1'b0, "R5 both flags high", 3, 1);
         if (byte_vld) begin
            if (exp_q.size() == 0)
               check(1'b0, "R7 unexpected byte strobe", int'(byte_out), -1);
            else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               check(byte_out == e, "R7 byte value", int'(byte_out), int'(e));
            end
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog all-requirements actual=%0d expected=%0d", cyc, 150000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic add_zeros(input int n);
      for (int i = 0; i < n; i++) bits_q.push_back(1'b0);
   endtask

   task automatic add_byte(input logic [7:0] b, input bit expect_it);
      for (int i = 7; i >= 0; i--) bits_q.push_back(b[i]);
      if (expect_it) exp_q.push_back(b);
   endtask

   // drive one sector: MFM-encode bits_q, ideal cell = 16 ticks
   task automatic run_sector(input bit en, input bit jit, input bit drift, input int trail);
      int  tr[$];
      int  s;
      int  k;
      int  j;
      int  total;
      bit  prev;
      s = 0;
      prev = 1'b0;
      for (int i = 0; i < bits_q.size(); i++) begin
         j = 0;
         if (jit) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            j = int'((lcg >> 16) % 3) - 1;
         end
         if (bits_q[i]) tr.push_back(s + 12 + j);
         else if (!prev) tr.push_back(s + 4 + j);
         prev = bits_q[i];
         s += (drift && (i % 4 == 3)) ? 17 : 16;
      end
      total = s + trail;
      k = 0;
      for (int t = 0; t < total; t++) begin
         @(posedge clk); #1;
         sector_pulse = (t >= 8);
         rd_en = en;
         rd_pulse = 1'b0;
         if (k < tr.size() && (t == tr[k] || t == tr[k] + 1)) rd_pulse = 1'b1;
         if (k < tr.size() && t == tr[k] + 1) k++;
      end
      @(posedge clk); #1;
      rd_pulse = 1'b0;
      if (trail > 0) repeat (4) @(posedge clk);
      bits_q.delete();
   endtask

   task automatic end_check(input string req, input bit ef, input bit ee);
      @(negedge clk);
      check(exp_q.size() == 0, {req, " bytes outstanding"}, exp_q.size(), 0);
      check(sync_found == ef, {req, " sync_found"}, int'(sync_found), int'(ef));
      check(sync_err == ee, {req, " sync_err"}, int'(sync_err), int'(ee));
      exp_q.delete();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(byte_out == 8'h00, "R1 byte_out reset", int'(byte_out), 0);
      check(byte_vld == 1'b0, "R1 byte_vld reset", int'(byte_vld), 0);
      check(sync_found == 1'b0, "R1 sync_found reset", int'(sync_found), 0);
      check(sync_err == 1'b0, "R1 sync_err reset", int'(sync_err), 0);
      rst_n = 1'b1;
      repeat (4) @(posedge clk);

      // R3 R4 R7: nominal sector, mixed patterns
      add_zeros(24); bits_q.push_back(1'b1);
      add_byte(8'hA5, 1); add_byte(8'h3C, 1); add_byte(8'hFF, 1);
      add_byte(8'h00, 1); add_byte(8'h81, 1);
      run_sector(1'b1, 1'b0, 1'b0, 6);
      end_check("R3 R4 R7 nominal", 1'b1, 1'b0);

      // R9: one-tick jitter
      add_zeros(24); bits_q.push_back(1'b1);
      add_byte(8'h5A, 1); add_byte(8'hC3, 1); add_byte(8'h0F, 1);
      add_byte(8'hF0, 1); add_byte(8'h96, 1); add_byte(8'h69, 1);
      run_sector(1'b1, 1'b1, 1'b0, 6);
      end_check("R9 jitter", 1'b1, 1'b0);

      // R9: slow bit rate drift
      add_zeros(24); bits_q.push_back(1'b1);
      add_byte(8'h00, 1); add_byte(8'h80, 1); add_byte(8'h01, 1);
      add_byte(8'hAA, 1); add_byte(8'h55, 1); add_byte(8'h00, 1);
      run_sector(1'b1, 1'b0, 1'b1, 6);
      end_check("R9 drift", 1'b1, 1'b0);

      // R4 boundary: exactly 16 zeros
      add_zeros(16); bits_q.push_back(1'b1); add_byte(8'h12, 1);
      run_sector(1'b1, 1'b0, 1'b0, 6);
      end_check("R4 sixteen zeros", 1'b1, 1'b0);

      // R5: 15 zeros then marker
      add_zeros(15); bits_q.push_back(1'b1); add_byte(8'h77, 0); add_byte(8'h42, 0);
      run_sector(1'b1, 1'b0, 1'b0, 6);
      end_check("R5 short preamble", 1'b0, 1'b1);

      // R6 boundary: marker in cell 64
      add_zeros(63); bits_q.push_back(1'b1); add_byte(8'hE7, 1);
      run_sector(1'b1, 1'b0, 1'b0, 6);
      end_check("R6 marker at window edge", 1'b1, 1'b0);

      // R6: no marker in window
      add_zeros(70); bits_q.push_back(1'b1); add_byte(8'h99, 0);
      run_sector(1'b1, 1'b0, 1'b0, 6);
      end_check("R6 window expired", 1'b0, 1'b1);

      // R2: edge with rd_en low stays idle
      add_zeros(24); bits_q.push_back(1'b1); add_byte(8'hC9, 0); add_byte(8'h3A, 0);
      run_sector(1'b0, 1'b0, 1'b0, 6);
      end_check("R2 disarmed sector", 1'b0, 1'b0);

      // R8: abort mid-byte, then a fresh read
      add_zeros(24); bits_q.push_back(1'b1); add_byte(8'hB4, 1);
      bits_q.push_back(1'b1); bits_q.push_back(1'b0);
      bits_q.push_back(1'b1); bits_q.push_back(1'b1);
      run_sector(1'b1, 1'b0, 1'b0, 0);
      @(negedge clk);
      check(exp_q.size() == 0, "R8 first byte before abort", exp_q.size(), 0);
      add_zeros(24); bits_q.push_back(1'b1); add_byte(8'h2D, 1);
      run_sector(1'b1, 1'b0, 1'b0, 6);
      end_check("R8 re-armed read", 1'b1, 1'b0);

      // stop: disarm edge
      add_zeros(2);
      run_sector(1'b0, 1'b0, 1'b0, 6);
      end_check("R2 final disarm", 1'b0, 1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule